// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This unit is a SIMD datapath stage that treats three 512-bit vectors as sixteen 32-bit lanes. In every lane it forms two signed 16-bit by 16-bit products from the two source vectors, adds both products to the matching lane of an accumulator vector, and registers the sum. All lanes read the accumulator value as it was presented with the operation, so one lane never sees another lane's new value.

Each operation can narrow the active width to 128, 256 or 512 bits. Lanes above the active width always come out as zero. A per-lane mask, gated by an enable, decides which active lanes take the new sum. A lane whose mask bit is clear is either zeroed or keeps its incoming accumulator value, depending on a mode select. A broadcast select makes every lane use the lowest 32-bit element of the second source as its pair of words.

The result sits in a register. A small two-state machine tracks output validity. It is in `ST_IDLE` when no result was produced on the last edge and in `ST_OUT` when one was. The transition `IDLE->OUT` or `OUT->OUT` is taken on any edge where `in_valid` is high. The transition `OUT->IDLE` or `IDLE->IDLE` is taken when it is low. Reset forces `ST_IDLE`.

Top module: `dpw_accum`

## Requirements
- R1: With masking disabled and full width selected, result lane i equals acc lane i plus a.word[2i]*b.word[2i] plus a.word[2i+1]*b.word[2i+1]. Word 2i is bits [32i+15:32i] and word 2i+1 is bits [32i+31:32i+16].
- R2: Every word is treated as a two's-complement signed value, and each product is a signed 32-bit quantity.
- R3: The lane sum wraps modulo 2^32. There is no saturation and no overflow indication.
- R4: `vlen_sel` 2'b00 selects 128 bits (lanes 0-3) and 2'b01 selects 256 bits (lanes 0-7). Every result bit at or above the selected width is zero.
- R5: `vlen_sel` 2'b10 selects 512 bits (all 16 lanes), and the spare code 2'b11 behaves the same as 2'b10.
- R6: When `mask_en` is 1, `zero_mode` is 1 and `mask[i]` is 0, active lane i of the result is zero.
- R7: When `mask_en` is 1, `zero_mode` is 0 and `mask[i]` is 0, active lane i of the result equals acc lane i unchanged.
- R8: When `mask_en` is 0, every active lane is computed whatever the value of `mask`.
- R9: Mask bits of lanes beyond the active width have no effect. Those lanes are zero in both zeroing and merging mode.
- R10: When `bcast` is 1, every lane uses bits [15:0] and [31:16] of the second source as its low and high words.
- R11: `out_valid` rises exactly one cycle after an edge with `in_valid` high, and a new operation is accepted on every cycle. While `in_valid` is low, `out_valid` is 0 and `result` holds its last value.
- R12: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| acc_in | input | 512 | Accumulator vector, sixteen 32-bit lanes |
| src_a | input | 512 | First source, thirty-two signed words |
| src_b | input | 512 | Second source, thirty-two signed words |
| mask | input | 16 | Per-lane write mask, bit i for lane i |
| mask_en | input | 1 | 1: apply mask; 0: all active lanes written |
| zero_mode | input | 1 | 1: masked-off lanes zeroed; 0: merged |
| bcast | input | 1 | 1: lane 0 element of src_b used in all lanes |
| vlen_sel | input | 2 | Active width: 00=128, 01=256, 10/11=512 |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 512 | Registered result vector |

## Verification
Every result is due on the first rising edge after the edge that accepted the operation, so `out_valid` and `result` are due one cycle after `in_valid`. The driver changes inputs on falling edges and pushes the expected vector into the scoreboard at that moment. The monitor samples shortly after each rising edge. When it sees `out_valid`, it pops exactly one entry. When `out_valid` is low, it checks that no entry is still waiting and that `result` has kept its last value. A result that arrives a cycle late or early therefore shows up as a miscompare instead of being absorbed.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    // Active width codes on vlen_sel
    typedef enum logic [1:0] {
        VL_QUARTER = 2'b00,   // 128 bits
        VL_HALF    = 2'b01,   // 256 bits
        VL_FULL    = 2'b10,   // 512 bits
        VL_SPARE   = 2'b11    // treated as full width
    } vlen_e;

    // Output validity state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;

endpackage

// File: rtl/dpw_lane_decode.sv
module dpw_lane_decode #(
    parameter int LANES = 16
) (
    input  logic [1:0]       vlen_sel,
    output logic [LANES-1:0] lane_act
);
    import dpw_pkg::*;

    localparam int N_QUARTER = LANES / 4;
    localparam int N_HALF    = LANES / 2;

    int unsigned n_act;

    always_comb begin
        unique case (vlen_e'(vlen_sel))
            VL_QUARTER: n_act = N_QUARTER;
            VL_HALF:    n_act = N_HALF;
            VL_FULL:    n_act = LANES;
            VL_SPARE:   n_act = LANES;
            default:    n_act = LANES;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_act
        assign lane_act[g] = (g < n_act);
    end

endmodule

// File: rtl/dpw_lane.sv
module dpw_lane #(
    parameter int WORD_W = 16
) (
    input  logic [2*WORD_W-1:0] acc,
    input  logic [2*WORD_W-1:0] a_pair,
    input  logic [2*WORD_W-1:0] b_pair,
    input  logic                active,
    input  logic                write_ok,
    input  logic                zero_mode,
    output logic [2*WORD_W-1:0] lane_out
);
    localparam int LANE_W = 2 * WORD_W;

    logic signed [LANE_W-1:0] prod_lo;
    logic signed [LANE_W-1:0] prod_hi;
    logic        [LANE_W-1:0] dot_sum;

    // Signed operands in a 32-bit context: both are sign-extended first
    assign prod_lo = $signed(a_pair[WORD_W-1:0]) * $signed(b_pair[WORD_W-1:0]);
    assign prod_hi = $signed(a_pair[LANE_W-1:WORD_W]) * $signed(b_pair[LANE_W-1:WORD_W]);
    assign dot_sum = acc + LANE_W'(prod_lo) + LANE_W'(prod_hi);

    always_comb begin
        if (!active)
            lane_out = '0;
        else if (write_ok)
            lane_out = dot_sum;
        else if (zero_mode)
            lane_out = '0;
        else
            lane_out = acc;
    end

endmodule

// File: rtl/dpw_accum.sv
module dpw_accum #(
    parameter int LANES  = 16,
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [LANES*2*WORD_W-1:0]     acc_in,
    input  logic [LANES*2*WORD_W-1:0]     src_a,
    input  logic [LANES*2*WORD_W-1:0]     src_b,
    input  logic [LANES-1:0]              mask,
    input  logic                          mask_en,
    input  logic                          zero_mode,
    input  logic                          bcast,
    input  logic [1:0]                    vlen_sel,
    output logic                          out_valid,
    output logic [LANES*2*WORD_W-1:0]     result
);
    import dpw_pkg::*;

    localparam int LANE_W = 2 * WORD_W;
    localparam int VEC_W  = LANES * LANE_W;

    out_state_e state_q, state_d;
    logic [LANES-1:0] lane_act;
    logic [VEC_W-1:0] next_vec;

    dpw_lane_decode #(.LANES(LANES)) u_decode (
        .vlen_sel (vlen_sel),
        .lane_act (lane_act)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] b_pick;
        assign b_pick = bcast ? src_b[LANE_W-1:0] : src_b[g*LANE_W +: LANE_W];

        dpw_lane #(.WORD_W(WORD_W)) u_lane (
            .acc       (acc_in[g*LANE_W +: LANE_W]),
            .a_pair    (src_a[g*LANE_W +: LANE_W]),
            .b_pair    (b_pick),
            .active    (lane_act[g]),
            .write_ok  (!mask_en || mask[g]),
            .zero_mode (zero_mode),
            .lane_out  (next_vec[g*LANE_W +: LANE_W])
        );
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (in_valid)
            result <= next_vec;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_OUT:  out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/dpw_accum_chk.sv
module dpw_accum_chk #(
    parameter int LANES  = 16,
    parameter int WORD_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [LANES*2*WORD_W-1:0] acc_in,
    input logic [LANES-1:0]          mask,
    input logic                      mask_en,
    input logic                      zero_mode,
    input logic [1:0]                vlen_sel,
    input logic                      out_valid,
    input logic [LANES*2*WORD_W-1:0] result
);
    localparam int LANE_W = 2 * WORD_W;
    localparam int VEC_W  = LANES * LANE_W;

    // R11: one-cycle latency
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11: no result without an operation
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11: result held while idle
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R4: upper bits zero at 128-bit width
    a_r4_quarter_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'b00) |=> (result[VEC_W-1:VEC_W/4] == '0));

    // R4: upper bits zero at 256-bit width
    a_r4_half_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'b01) |=> (result[VEC_W-1:VEC_W/2] == '0));

    // R6: masked-off lane 0 zeroed
    a_r6_zeroing: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !mask[0] && zero_mode) |=> (result[LANE_W-1:0] == '0));

    // R7: masked-off lane 0 merged
    a_r7_merging: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !mask[0] && !zero_mode)
            |=> (result[LANE_W-1:0] == $past(acc_in[LANE_W-1:0])));

endmodule

bind dpw_accum dpw_accum_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .acc_in    (acc_in),
    .mask      (mask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .vlen_sel  (vlen_sel),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/dpw_accum_bench.sv
module dpw_accum_bench;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] acc_in = '0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [15:0]   mask = '0;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic          bcast = 1'b0;
    logic [1:0]    vlen_sel = 2'b10;
    logic          out_valid;
    logic [VW-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];
    logic [VW-1:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpw_accum u_dpw_accum (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
        .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast(bcast), .vlen_sel(vlen_sel),
        .out_valid(out_valid), .result(result)
    );

    // Reference model written from the requirements
    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] acc, input logic [VW-1:0] a, input logic [VW-1:0] b,
        input logic [15:0] m, input logic men, input logic zm, input logic bc,
        input logic [1:0] vl);
        logic [VW-1:0] r;
        int n;
        n = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] bw;
            logic [31:0] lane;
            int x0, x1, y0, y1;
            bw = bc ? b[31:0] : b[i*32 +: 32];
            x0 = int'(shortint'(a[i*32 +: 16]));
            x1 = int'(shortint'(a[i*32+16 +: 16]));
            y0 = int'(shortint'(bw[15:0]));
            y1 = int'(shortint'(bw[31:16]));
            lane = acc[i*32 +: 32] + 32'(x0 * y0) + 32'(x1 * y1);
            if (i >= n)
                lane = '0;
            else if (men && !m[i])
                lane = zm ? 32'd0 : acc[i*32 +: 32];
            r[i*32 +: 32] = lane;
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic apply(input logic [VW-1:0] acc, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input logic [15:0] m,
                         input logic men, input logic zm, input logic bc,
                         input logic [1:0] vl, input string tag);
        @(negedge clk);
        acc_in = acc; src_a = a; src_b = b; mask = m;
        mask_en = men; zero_mode = zm; bcast = bc; vlen_sel = vl;
        in_valid = 1'b1;
        exp_q.push_back(model(acc, a, b, m, men, zm, bc, vl));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            acc_in = rnd_vec(); src_a = rnd_vec(); src_b = rnd_vec();
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                last_exp = '0;
            end else if (out_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL R11: out_valid=1 expected=0 (no operation pending)");
                end else begin
                    logic [VW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (result !== e) begin
                        n_fails++;
                        $display("FAIL %s: result=%h expected=%h", t, result, e);
                    end
                    last_exp = e;
                end
            end else begin
                n_checks++;
                if (exp_q.size() != 0) begin
                    n_fails++;
                    $display("FAIL R11: out_valid=0 expected=1");
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else if (result !== last_exp) begin
                    n_fails++;
                    $display("FAIL R11: held result=%h expected=%h", result, last_exp);
                end
            end
        end
    end

    task automatic reset_check();
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_fails++;
            $display("FAIL R12: out_valid=%b result=%h expected out_valid=0 result=0",
                     out_valid, result);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run incomplete, expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] va, vb, vc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_check(); // R12

        // R1: plain dot product, full width, several patterns, back to back (R11)
        for (int k = 0; k < 6; k++)
            apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b0, 1'b0, 2'b10, "R1");
        idle(2);

        // R2: negative words, lane 0: 10 + (-2*4) + (3*-5) = -13
        va = rnd_vec(); vb = rnd_vec(); vc = rnd_vec();
        va[31:0] = {16'd3, 16'hFFFE};
        vb[31:0] = {16'hFFFB, 16'd4};
        vc[31:0] = 32'd10;
        apply(vc, va, vb, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b10, "R2");
        idle(1);
        n_checks++;
        if (last_exp[31:0] !== 32'hFFFF_FFF3) begin
            n_fails++;
            $display("FAIL R2: model lane0=%h expected=%h", last_exp[31:0], 32'hFFFF_FFF3);
        end

        // R3: 0x7FFFFFFF + 2^30 + 2^30 wraps to 0xFFFFFFFF
        va = {32{16'h8000}};
        vc = {16{32'h7FFF_FFFF}};
        apply(vc, va, va, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b10, "R3");
        apply({16{32'hFFFF_FFFF}}, {32{16'h7FFF}}, {32{16'h7FFF}},
              16'h0000, 1'b0, 1'b0, 1'b0, 2'b10, "R3");
        idle(1);

        // R4: narrower widths
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, "R4");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b0, 1'b0, 2'b01, "R4");
        // R5: spare code is full width
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b0, 1'b0, 2'b11, "R5");
        idle(1);

        // R6: zeroing masks
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'hA5A5, 1'b1, 1'b1, 1'b0, 2'b10, "R6");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b1, 1'b1, 1'b0, 2'b10, "R6");
        // R7: merging masks
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h5A3C, 1'b1, 1'b0, 1'b0, 2'b10, "R7");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b1, 1'b0, 1'b0, 2'b01, "R7");
        // R8: mask ignored when disabled
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b1, 1'b0, 2'b10, "R8");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h1234, 1'b0, 1'b0, 1'b0, 2'b10, "R8");
        idle(2);

        // R9: mask bits above the active width have no effect
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h00F0, 1'b1, 1'b0, 1'b0, 2'b00, "R9");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'hFF0F, 1'b1, 1'b1, 1'b0, 2'b00, "R9");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0F00, 1'b1, 1'b0, 1'b0, 2'b01, "R9");
        idle(1);

        // R10: broadcast of lane-0 element
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h0000, 1'b0, 1'b0, 1'b1, 2'b10, "R10");
        apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'h3C3C, 1'b1, 1'b0, 1'b1, 2'b01, "R10");
        idle(3);

        // R11: alternating valid
        for (int k = 0; k < 4; k++) begin
            apply(rnd_vec(), rnd_vec(), rnd_vec(), 16'(k * 16'h1111), 1'b1, k[0], k[1],
                  2'b10, "R11");
            idle(1);
        end
        idle(2);

        // R12: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reset_check(); // R12
        idle(2);

        finish_run();
    end

endmodule